// File: doc/BRIEF.md
# Sign-Preserving Word-Length Quantizer

This block lowers the effective resolution of a signed sample stream while leaving the bus width unchanged. Each sample that arrives with its valid strobe is shifted arithmetically to the right. The shift distance is the data width minus the selected word length. The vacated upper bits fill with copies of the sign. Downstream filters keep their full-width datapath, but only the low-order bits go on toggling, so dynamic power drops as the word length shrinks.

The word length comes from a two-bit select that is sampled together with each valid sample. Four lengths are available: 1, 2, 4 and 8 bits, each limited to the data width. The result is registered, so a quantized sample appears one clock after it was presented. When no sample arrives, the output word holds its value. This keeps the downstream bus from switching between samples.

Top module: `wl_quantizer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_vld is 0 and out_data is all zeros.
- R2: out_vld equals in_vld delayed by exactly one clock.
- R3: A valid sample is presented as out_data one clock later. out_data equals in_data shifted arithmetically right by DATA_W minus Nb. Nb is set by wl_sel: 2'b00 gives 1 bit, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 8, each clamped to DATA_W.
- R4: The most significant bit of out_data equals the most significant bit of the input sample that produced it.
- R5: Every bit of out_data from position Nb-1 up to DATA_W-1 equals the sign bit of the sample.
- R6: With wl_sel = 2'b00 (Nb = 1), a non-negative sample gives all zeros and a negative sample gives all ones.
- R7: wl_sel is sampled with each valid sample only. A select change applies from the next valid sample on, and each sample uses the select that was present with it, also when samples arrive back to back.
- R8: In a cycle where in_vld is 0, out_data keeps the value it held before, whatever in_data and wl_sel carry.
- R9: When Nb equals DATA_W (wl_sel = 2'b11 at the default width), out_data equals the input sample unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input sample is valid this cycle |
| in_data | input | DATA_W | Signed two's-complement input sample |
| wl_sel | input | 2 | Word-length select code, sampled with in_vld |
| out_vld | output | 1 | Quantized sample is valid this cycle |
| out_data | output | DATA_W | Quantized sample, sign-extended to full width |

## Verification
The properties assume that wl_sel holds one of its four codes whenever in_vld is high. They also assume that in_vld is low during reset, so that the first post-reset comparison is against a quiet input. The stimulus draws wl_sel from two random bits, so every code is legal by construction, and it holds in_vld at 0 until reset is released. The random phase also drives arbitrary in_data and wl_sel values while in_vld is low. This exercises the hold rule under the assumption that idle inputs carry no meaning.

// File: rtl/wlq_pkg.sv
package wlq_pkg;

  typedef enum logic [1:0] {
    WL_1B = 2'b00,
    WL_2B = 2'b01,
    WL_4B = 2'b10,
    WL_8B = 2'b11
  } wl_code_e;

  localparam int unsigned WL_CODES = 4;

  // Number of significant bits kept for a code, limited to the bus width.
  function automatic int unsigned wl_bits(input int unsigned code, input int unsigned width);
    int unsigned b;
    b = 32'd1 << code;
    return (b > width) ? width : b;
  endfunction

  // Shift distance that leaves wl_bits significant bits.
  function automatic int unsigned wl_shift(input int unsigned code, input int unsigned width);
    return width - wl_bits(code, width);
  endfunction

endpackage

// File: rtl/wlq_decode.sv
module wlq_decode
  import wlq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SH_W  = $clog2(DATA_W + 1)
) (
  input  wl_code_e          code,
  output logic [SH_W-1:0]   nb,
  output logic [SH_W-1:0]   shamt
);

  always_comb begin
    nb    = SH_W'(wl_bits(int'(code), DATA_W));
    shamt = SH_W'(wl_shift(int'(code), DATA_W));
  end

  // R3: kept bits plus shift always span the bus
  always_comb begin
    assert_span_R3: assert ((32'(nb) + 32'(shamt)) == DATA_W);
  end

endmodule

// File: rtl/wlq_shifter.sv
module wlq_shifter
  import wlq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] din,
  input  wl_code_e          code,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] cand [WL_CODES];

  // Each code has a constant shift: pure wiring plus sign fan-out.
  for (genvar g = 0; g < int'(WL_CODES); g++) begin : g_cand
    localparam int unsigned SH = wl_shift(g, DATA_W);
    assign cand[g] = DATA_W'($signed(din) >>> SH);
  end

  always_comb begin
    dout = cand[code];
  end

endmodule

// File: rtl/wlq_out_reg.sv
module wlq_out_reg #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SH_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W-1:0] nxt_data,
  input  logic [SH_W-1:0]   nb,
  input  logic [SH_W-1:0]   shamt,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data
);

  logic [DATA_W-1:0] hold_q;
  logic              vld_q;
  logic              load_en;

  assign load_en = in_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      hold_q <= '0;
    end else begin
      vld_q <= in_vld;
      if (load_en) hold_q <= nxt_data;
    end
  end

  assign out_vld  = vld_q;
  assign out_data = hold_q;

  // Barrel-shift reference, independent of the fixed-shift candidates.
  function automatic logic [DATA_W-1:0] sar(input logic [DATA_W-1:0] v, input logic [SH_W-1:0] s);
    return DATA_W'($signed(v) >>> s);
  endfunction

  // True when bits nb-1 .. DATA_W-1 all match the top bit.
  function automatic logic sign_window_ok(input logic [DATA_W-1:0] v, input logic [SH_W-1:0] n);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < int'(DATA_W); i++) begin
      if (i >= int'(n) - 1 && v[i] != v[DATA_W-1]) ok = 1'b0;
    end
    return ok;
  endfunction

  assert_vld_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_vld == $past(in_vld)));

  assert_shift_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && out_vld) |-> (out_data == sar($past(in_data), $past(shamt))));

  assert_sign_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && out_vld) |-> (out_data[DATA_W-1] == $past(in_data[DATA_W-1])));

  assert_sign_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && out_vld) |-> sign_window_ok(out_data, $past(nb)));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_vld)) |-> $stable(out_data));

endmodule

// File: rtl/wl_quantizer.sv
module wl_quantizer
  import wlq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        wl_sel,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data
);

  localparam int unsigned SH_W = $clog2(DATA_W + 1);

  wl_code_e          code;
  logic [SH_W-1:0]   sel_nb;
  logic [SH_W-1:0]   sel_shamt;
  logic [DATA_W-1:0] shifted;

  assign code = wl_code_e'(wl_sel);

  wlq_decode #(.DATA_W(DATA_W)) u_dec (
    .code  (code),
    .nb    (sel_nb),
    .shamt (sel_shamt)
  );

  wlq_shifter #(.DATA_W(DATA_W)) u_shf (
    .din  (in_data),
    .code (code),
    .dout (shifted)
  );

  wlq_out_reg #(.DATA_W(DATA_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .in_data  (in_data),
    .nxt_data (shifted),
    .nb       (sel_nb),
    .shamt    (sel_shamt),
    .out_vld  (out_vld),
    .out_data (out_data)
  );

endmodule

// File: tb/sim_wl_quantizer.sv
module sim_wl_quantizer;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_vld = 1'b0;
  logic [W-1:0] in_data = '0;
  logic [1:0]   wl_sel = 2'b00;
  logic         out_vld;
  logic [W-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  wl_quantizer #(.DATA_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
    .wl_sel(wl_sel), .out_vld(out_vld), .out_data(out_data)
  );

  // Expected value by floor division: v / 2^(W - Nb), rounded toward minus infinity.
  function automatic logic [W-1:0] model(input logic [W-1:0] d, input logic [1:0] s);
    int nb, div, v, q;
    nb  = (1 << s) > W ? W : (1 << s);
    div = 1 << (W - nb);
    v   = d[W-1] ? int'(d) - (1 << W) : int'(d);
    if (v >= 0) q = v / div;
    else        q = -((-v + div - 1) / div);
    return W'(q);
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Present one cycle of input, then sample the result just after the edge.
  task automatic step(input logic v, input logic [W-1:0] d, input logic [1:0] s);
    @(negedge clk);
    in_vld = v; in_data = d; wl_sel = s;
    @(posedge clk); #1;
  endtask

  task automatic sample(input string req, input logic [W-1:0] d, input logic [1:0] s);
    step(1'b1, d, s);
    chk({req, " vld"}, W'(out_vld), W'(1));
    chk(req, out_data, model(d, s));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] prev;
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset vld", W'(out_vld), W'(0));
    chk("R1 reset data", out_data, '0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 post-reset vld", W'(out_vld), W'(0));
    chk("R1 post-reset data", out_data, '0);

    // R3, R4, R5: extremes at every code
    for (int s = 0; s < 4; s++) begin
      sample("R3 min", 8'h80, 2'(s));
      chk("R4 sign min", W'(out_data[W-1]), W'(1));
      sample("R3 max", 8'h7F, 2'(s));
      chk("R4 sign max", W'(out_data[W-1]), W'(0));
      sample("R5 minus one", 8'hFF, 2'(s));
    end
    // R6: one-bit word leaves only the sign
    sample("R6 small pos", 8'h01, 2'b00);
    chk("R6 zeros", out_data, 8'h00);
    sample("R6 small neg", 8'hC3, 2'b00);
    chk("R6 ones", out_data, 8'hFF);
    // R9: full width passes through
    sample("R9 pass", 8'hA5, 2'b11);
    chk("R9 identity", out_data, 8'hA5);
    // R7: back-to-back samples with changing select
    sample("R7 sel4", 8'h5A, 2'b10);
    chk("R7 4-bit", out_data, 8'h05);
    sample("R7 sel2", 8'h5A, 2'b01);
    chk("R7 2-bit", out_data, 8'h01);
    sample("R7 sel8", 8'h5A, 2'b11);
    chk("R7 8-bit", out_data, 8'h5A);
    // R7/R8: select change while idle has no effect on the held word
    prev = out_data;
    step(1'b0, 8'h80, 2'b00);
    chk("R2 idle vld", W'(out_vld), W'(0));
    chk("R8 hold", out_data, prev);
    step(1'b0, 8'h33, 2'b10);
    chk("R8 hold again", out_data, prev);
    sample("R7 new sel applied", 8'h80, 2'b10);
    chk("R7 4-bit neg", out_data, 8'hF8);

    // Random phase
    prev = out_data;
    for (int i = 0; i < 400; i++) begin
      logic v;
      logic [W-1:0] d;
      logic [1:0] s;
      v = ($urandom % 4) != 0;
      d = W'($urandom);
      s = 2'($urandom);
      step(v, d, s);
      chk("R2 random vld", W'(out_vld), W'(v));
      if (v) begin
        chk("R3 random value", out_data, model(d, s));
        chk("R4 random sign", W'(out_data[W-1]), W'(d[W-1]));
        prev = out_data;
      end else begin
        chk("R8 random hold", out_data, prev);
      end
    end

    finish_run();
  end

endmodule